// File: doc/BRIEF.md
# Remap State Configuration Unit

This block holds the control state that ties the operand slots of a vector instruction to shape registers. There are five slots: three sources (A, B, C) and two results (first and second). Each slot has a 2-bit selector that names one of four shape registers, and a bit in an enable mask. A persistence flag decides how long the binding lasts. The decoder reads the per-slot selectors and enables directly from the outputs.

Three update commands change the state. A direct bind loads every selector, the enable mask and the persistence flag in one step. A masked bulk assign clears the state and then hands out shape numbers in slot order, one for each set mask bit. A single-slot assign changes one slot and sets persistence. When persistence is clear, the binding lasts for one vector instruction: the first retire afterwards clears the enable mask. A new maximum-length setting turns remapping off. Writes into the shape registers themselves are represented only by a one-cycle strobe per shape index.

Top module: `remap_cfg_unit`

## Requirements
- R1: After reset all selectors, the enable mask, the persistence flag and the shape write strobes are zero.
- R2: A bind command (`bind_valid`) loads `slot_sel`, `slot_en` and `persist` from its operands in the cycle after the command edge, and asserts no shape write strobe.
- R3: A bulk assign (`asg_valid`, `asg_single`=0) clears every selector and enable bit. It walks the slots in order source A, B, C, result 1, result 2 (mask bits 4 down to 0). Each slot whose bit is set receives the next shape number, counting from 0, and the command clears persistence. A zero mask leaves everything cleared.
- R4: In bulk assign the shape counter wraps modulo 4, so with all five mask bits set source A and result 2 both receive shape 0.
- R5: A single-slot assign (`asg_single`=1) decodes mask bits 4:2 as a slot code (0=source A ... 4=result 2) and bits 1:0 as the shape. Only that slot's selector and enable bit change, and persistence is set. Examples: mask 0b01110 binds result 1 to shape 2, and mask 0b10011 binds result 2 to shape 3.
- R6: A single-slot assign with a slot code of 5, 6 or 7 leaves selectors, enables and persistence unchanged and raises no strobe.
- R7: Each assign command pulses `shape_wr` for exactly one cycle, in the same cycle the new state appears, with one bit set for every shape index it allocated.
- R8: With persistence clear, the first `vec_retire` clears the enable mask and keeps the selectors.
- R9: With persistence set, `vec_retire` leaves the state unchanged.
- R10: `maxvl_set` clears the enable mask and the persistence flag and keeps the selectors.
- R11: When several inputs are active in one cycle, only one applies, in this priority: bind, then assign, then `maxvl_set`, then `vec_retire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bind_valid | input | 1 | Direct bind command |
| bind_sel | input | 10 | Selectors to load, slot i at bits 2i+1:2i (slot 0 = source A) |
| bind_en | input | 5 | Enable mask to load, bit 4 = source A ... bit 0 = result 2 |
| bind_persist | input | 1 | Persistence value to load |
| asg_valid | input | 1 | Assign command |
| asg_single | input | 1 | 0 = bulk assign, 1 = single-slot assign |
| asg_mask | input | 5 | Assign mask operand |
| maxvl_set | input | 1 | New maximum vector length written |
| vec_retire | input | 1 | A vector instruction retired |
| slot_sel | output | 10 | Current shape selector per slot, same packing as bind_sel |
| slot_en | output | 5 | Current enable mask, same bit order as bind_en |
| persist | output | 1 | Current persistence flag |
| shape_wr | output | 4 | One-cycle write strobe per shape index |

## Verification
The hardest case to reach is a cycle where commands collide, for example an assign that arrives together with a retire while a one-shot binding is live. A retire then has to lose to the new binding instead of clearing it. The stimulus first sets up a non-persistent binding with enables set, then fires two inputs on the same edge. It does this for bind against bulk assign, and for single assign against retire. The wrap of the shape counter and the out-of-range slot codes are each reached by their own directed mask values, run on top of a known non-zero state so that any change would be visible.

// File: rtl/remap_cfg_pkg.sv
package remap_cfg_pkg;

   // Kind of state update selected for one cycle
   typedef enum logic [2:0] {
      UPD_HOLD   = 3'd0,
      UPD_BIND   = 3'd1,
      UPD_BULK   = 3'd2,
      UPD_SINGLE = 3'd3,
      UPD_MAXVL  = 3'd4,
      UPD_RETIRE = 3'd5
   } upd_kind_e;

   // Enable masks are ordered MSB-first: slot 0 lives in the top bit
   function automatic int en_bit(input int slot, input int nslot);
      return nslot - 1 - slot;
   endfunction

endpackage

// File: rtl/remap_bulk_alloc.sv
module remap_bulk_alloc #(
   parameter int NSLOT  = 5,
   parameter int NSHAPE = 4,
   localparam int SELW  = $clog2(NSHAPE)
) (
   input  logic [NSLOT-1:0]      mask,
   output logic [NSLOT*SELW-1:0] sel_o,
   output logic [NSLOT-1:0]      en_o,
   output logic [NSHAPE-1:0]     stb_o
);
   import remap_cfg_pkg::*;

   // running shape counter per slot boundary; wraps modulo NSHAPE
   logic [SELW-1:0] cnt [NSLOT+1];

   assign cnt[0] = '0;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam int EB = NSLOT - 1 - g;
      logic take;
      assign take = mask[EB];
      assign cnt[g+1] = take ? cnt[g] + SELW'(1) : cnt[g];
      assign sel_o[g*SELW +: SELW] = take ? cnt[g] : '0;
      assign en_o[EB] = take;
   end

   always_comb begin
      stb_o = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (mask[en_bit(i, NSLOT)]) stb_o[cnt[i]] = 1'b1;
      end
   end

endmodule

// File: rtl/remap_single_dec.sv
module remap_single_dec #(
   parameter int NSLOT  = 5,
   parameter int NSHAPE = 4,
   localparam int SELW  = $clog2(NSHAPE),
   localparam int CODEW = NSLOT - SELW
) (
   input  logic [NSLOT-1:0]      mask,
   input  logic [NSLOT*SELW-1:0] cur_sel,
   input  logic [NSLOT-1:0]      cur_en,
   output logic                  hit_o,
   output logic [NSLOT*SELW-1:0] sel_o,
   output logic [NSLOT-1:0]      en_o,
   output logic [NSHAPE-1:0]     stb_o
);

   logic [CODEW-1:0] code;
   logic [SELW-1:0]  shp;

   assign code  = mask[NSLOT-1 -: CODEW];
   assign shp   = mask[SELW-1:0];
   assign hit_o = ({1'b0, code} < (CODEW+1)'(NSLOT));

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam int EB = NSLOT - 1 - g;
      logic pick;
      assign pick = hit_o && (code == CODEW'(g));
      assign sel_o[g*SELW +: SELW] = pick ? shp : cur_sel[g*SELW +: SELW];
      assign en_o[EB] = pick ? 1'b1 : cur_en[EB];
   end

   for (genvar s = 0; s < NSHAPE; s++) begin : g_stb
      assign stb_o[s] = hit_o && (shp == SELW'(s));
   end

endmodule

// File: rtl/remap_cmd_arb.sv
module remap_cmd_arb (
   input  logic bind_valid,
   input  logic asg_valid,
   input  logic asg_single,
   input  logic single_hit,
   input  logic maxvl_set,
   input  logic vec_retire,
   input  logic persist,
   output remap_cfg_pkg::upd_kind_e kind_o
);
   import remap_cfg_pkg::*;

   always_comb begin
      if (bind_valid)                   kind_o = UPD_BIND;
      else if (asg_valid && !asg_single) kind_o = UPD_BULK;
      else if (asg_valid)               kind_o = single_hit ? UPD_SINGLE : UPD_HOLD;
      else if (maxvl_set)               kind_o = UPD_MAXVL;
      else if (vec_retire && !persist)  kind_o = UPD_RETIRE;
      else                              kind_o = UPD_HOLD;
   end

endmodule

// File: rtl/remap_state_reg.sv
module remap_state_reg #(
   parameter int NSLOT  = 5,
   parameter int NSHAPE = 4,
   localparam int SELW  = $clog2(NSHAPE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  remap_cfg_pkg::upd_kind_e kind,
   input  logic [NSLOT*SELW-1:0]    bind_sel,
   input  logic [NSLOT-1:0]         bind_en,
   input  logic                     bind_persist,
   input  logic [NSLOT*SELW-1:0]    bulk_sel,
   input  logic [NSLOT-1:0]         bulk_en,
   input  logic [NSHAPE-1:0]        bulk_stb,
   input  logic [NSLOT*SELW-1:0]    one_sel,
   input  logic [NSLOT-1:0]         one_en,
   input  logic [NSHAPE-1:0]        one_stb,
   output logic [NSLOT*SELW-1:0]    sel_q,
   output logic [NSLOT-1:0]         en_q,
   output logic                     pst_q,
   output logic [NSHAPE-1:0]        stb_q
);
   import remap_cfg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= '0;
         pst_q <= 1'b0;
         stb_q <= '0;
      end else begin
         stb_q <= '0;
         unique case (kind)
            UPD_BIND: begin
               sel_q <= bind_sel;
               en_q  <= bind_en;
               pst_q <= bind_persist;
            end
            UPD_BULK: begin
               sel_q <= bulk_sel;
               en_q  <= bulk_en;
               pst_q <= 1'b0;
               stb_q <= bulk_stb;
            end
            UPD_SINGLE: begin
               sel_q <= one_sel;
               en_q  <= one_en;
               pst_q <= 1'b1;
               stb_q <= one_stb;
            end
            UPD_MAXVL: begin
               en_q  <= '0;
               pst_q <= 1'b0;
            end
            UPD_RETIRE: en_q <= '0;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/remap_cfg_unit.sv
module remap_cfg_unit #(
   parameter int NSLOT  = 5,
   parameter int NSHAPE = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bind_valid,
   input  logic [NSLOT*$clog2(NSHAPE)-1:0]   bind_sel,
   input  logic [NSLOT-1:0]                  bind_en,
   input  logic                              bind_persist,
   input  logic                              asg_valid,
   input  logic                              asg_single,
   input  logic [NSLOT-1:0]                  asg_mask,
   input  logic                              maxvl_set,
   input  logic                              vec_retire,
   output logic [NSLOT*$clog2(NSHAPE)-1:0]   slot_sel,
   output logic [NSLOT-1:0]                  slot_en,
   output logic                              persist,
   output logic [NSHAPE-1:0]                 shape_wr
);
   import remap_cfg_pkg::*;

   localparam int SELW = $clog2(NSHAPE);

   // elaboration-time parameter checks
   if (NSHAPE < 2 || (1 << SELW) != NSHAPE) begin : g_bad_shape
      $error("NSHAPE must be a power of two of at least 2");
   end
   if (NSLOT <= SELW || (1 << (NSLOT - SELW)) < NSLOT) begin : g_bad_slot
      $error("NSLOT too small to hold a slot code above the shape field");
   end

   logic [NSLOT*SELW-1:0] bulk_sel, one_sel;
   logic [NSLOT-1:0]      bulk_en, one_en;
   logic [NSHAPE-1:0]     bulk_stb, one_stb;
   logic                  one_hit;
   upd_kind_e             kind;

   remap_bulk_alloc #(.NSLOT(NSLOT), .NSHAPE(NSHAPE)) u_bulk (
      .mask  (asg_mask),
      .sel_o (bulk_sel),
      .en_o  (bulk_en),
      .stb_o (bulk_stb)
   );

   remap_single_dec #(.NSLOT(NSLOT), .NSHAPE(NSHAPE)) u_one (
      .mask    (asg_mask),
      .cur_sel (slot_sel),
      .cur_en  (slot_en),
      .hit_o   (one_hit),
      .sel_o   (one_sel),
      .en_o    (one_en),
      .stb_o   (one_stb)
   );

   remap_cmd_arb u_arb (
      .bind_valid (bind_valid),
      .asg_valid  (asg_valid),
      .asg_single (asg_single),
      .single_hit (one_hit),
      .maxvl_set  (maxvl_set),
      .vec_retire (vec_retire),
      .persist    (persist),
      .kind_o     (kind)
   );

   remap_state_reg #(.NSLOT(NSLOT), .NSHAPE(NSHAPE)) u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .kind         (kind),
      .bind_sel     (bind_sel),
      .bind_en      (bind_en),
      .bind_persist (bind_persist),
      .bulk_sel     (bulk_sel),
      .bulk_en      (bulk_en),
      .bulk_stb     (bulk_stb),
      .one_sel      (one_sel),
      .one_en       (one_en),
      .one_stb      (one_stb),
      .sel_q        (slot_sel),
      .en_q         (slot_en),
      .pst_q        (persist),
      .stb_q        (shape_wr)
   );

endmodule

// File: rtl/remap_cfg_unit_chk.sv
module remap_cfg_unit_chk #(
   parameter int NSLOT  = 5,
   parameter int NSHAPE = 4,
   localparam int SELW  = $clog2(NSHAPE),
   localparam int CODEW = NSLOT - SELW
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bind_valid,
   input logic [NSLOT*SELW-1:0] bind_sel,
   input logic [NSLOT-1:0]      bind_en,
   input logic                  bind_persist,
   input logic                  asg_valid,
   input logic                  asg_single,
   input logic [NSLOT-1:0]      asg_mask,
   input logic                  maxvl_set,
   input logic                  vec_retire,
   input logic [NSLOT*SELW-1:0] slot_sel,
   input logic [NSLOT-1:0]      slot_en,
   input logic                  persist,
   input logic [NSHAPE-1:0]     shape_wr
);

   logic code_ok;
   assign code_ok = ({1'b0, asg_mask[NSLOT-1 -: CODEW]} < (CODEW+1)'(NSLOT));

   // R2
   bind_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bind_valid |=> (slot_sel == $past(bind_sel)) && (slot_en == $past(bind_en))
                     && (persist == $past(bind_persist)) && (shape_wr == '0));

   // R3
   bulk_nopst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asg_valid && !asg_single && !bind_valid) |=> !persist);

   // R5
   single_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asg_valid && asg_single && !bind_valid && code_ok) |=> persist && $onehot(shape_wr));

   // R6
   single_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asg_valid && asg_single && !bind_valid && !code_ok)
         |=> $stable(slot_sel) && $stable(slot_en) && $stable(persist) && (shape_wr == '0));

   // R7
   stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shape_wr != '0) |-> $past(asg_valid && !bind_valid));

   // R8
   retire_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_retire && !persist && !bind_valid && !asg_valid && !maxvl_set)
         |=> (slot_en == '0) && $stable(slot_sel));

   // R9
   retire_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (persist && !bind_valid && !asg_valid && !maxvl_set)
         |=> $stable(slot_en) && $stable(slot_sel) && persist);

   // R10
   maxvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (maxvl_set && !bind_valid && !asg_valid) |=> (slot_en == '0) && !persist);

endmodule

bind remap_cfg_unit remap_cfg_unit_chk #(.NSLOT(NSLOT), .NSHAPE(NSHAPE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bind_valid   (bind_valid),
   .bind_sel     (bind_sel),
   .bind_en      (bind_en),
   .bind_persist (bind_persist),
   .asg_valid    (asg_valid),
   .asg_single   (asg_single),
   .asg_mask     (asg_mask),
   .maxvl_set    (maxvl_set),
   .vec_retire   (vec_retire),
   .slot_sel     (slot_sel),
   .slot_en      (slot_en),
   .persist      (persist),
   .shape_wr     (shape_wr)
);

// File: tb/remap_cfg_unit_test.sv
module remap_cfg_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bind_valid = 1'b0;
   logic [9:0] bind_sel = '0;
   logic [4:0] bind_en = '0;
   logic       bind_persist = 1'b0;
   logic       asg_valid = 1'b0;
   logic       asg_single = 1'b0;
   logic [4:0] asg_mask = '0;
   logic       maxvl_set = 1'b0;
   logic       vec_retire = 1'b0;
   logic [9:0] slot_sel;
   logic [4:0] slot_en;
   logic       persist;
   logic [3:0] shape_wr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   remap_cfg_unit uut (
      .clk(clk), .rst_n(rst_n),
      .bind_valid(bind_valid), .bind_sel(bind_sel), .bind_en(bind_en),
      .bind_persist(bind_persist),
      .asg_valid(asg_valid), .asg_single(asg_single), .asg_mask(asg_mask),
      .maxvl_set(maxvl_set), .vec_retire(vec_retire),
      .slot_sel(slot_sel), .slot_en(slot_en), .persist(persist), .shape_wr(shape_wr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic state_is(input string req, input logic [9:0] s, input logic [4:0] e,
                           input logic p, input logic [3:0] w);
      chk({req, " sel"}, 32'(slot_sel), 32'(s));
      chk({req, " en"},  32'(slot_en),  32'(e));
      chk({req, " pst"}, 32'(persist),  32'(p));
      chk({req, " wr"},  32'(shape_wr), 32'(w));
   endtask

   // drive on a falling edge, release and sample on the next falling edge
   task automatic step;
      @(negedge clk);
      bind_valid = 0; asg_valid = 0; asg_single = 0; asg_mask = '0;
      maxvl_set = 0; vec_retire = 0;
   endtask

   task automatic do_bind(input logic [9:0] s, input logic [4:0] e, input logic p);
      bind_valid = 1; bind_sel = s; bind_en = e; bind_persist = p;
      step();
   endtask

   task automatic do_asg(input logic single, input logic [4:0] m);
      asg_valid = 1; asg_single = single; asg_mask = m;
      step();
   endtask

   task automatic t_reset;
      state_is("R1 reset", 10'h000, 5'b00000, 0, 4'b0000);
   endtask

   task automatic t_bind_oneshot;
      do_bind(10'h139, 5'b10110, 0);
      state_is("R2 bind", 10'h139, 5'b10110, 0, 4'b0000);
      vec_retire = 1; step();
      state_is("R8 retire clears", 10'h139, 5'b00000, 0, 4'b0000);
      vec_retire = 1; step();
      state_is("R8 second retire", 10'h139, 5'b00000, 0, 4'b0000);
   endtask

   task automatic t_persist;
      do_bind(10'h139, 5'b11111, 1);
      vec_retire = 1; step();
      vec_retire = 1; step();
      state_is("R9 persistent retire", 10'h139, 5'b11111, 1, 4'b0000);
      maxvl_set = 1; step();
      state_is("R10 maxvl", 10'h139, 5'b00000, 0, 4'b0000);
   endtask

   task automatic t_bulk;
      do_bind(10'h3FF, 5'b11111, 1);
      do_asg(0, 5'b10101);
      state_is("R3 bulk 10101", 10'h210, 5'b10101, 0, 4'b0111);
      step();
      chk("R7 strobe one cycle", 32'(shape_wr), 32'h0);
      do_asg(0, 5'b11111);
      state_is("R4 bulk wrap", 10'h0E4, 5'b11111, 0, 4'b1111);
      do_asg(0, 5'b01001);
      state_is("R3 bulk 01001", 10'h100, 5'b01001, 0, 4'b0011);
   endtask

   task automatic t_single;
      do_asg(1, 5'b01110);
      state_is("R5 single result1", 10'h180, 5'b01011, 1, 4'b0100);
      do_asg(1, 5'b10011);
      state_is("R5 single result2", 10'h380, 5'b01011, 1, 4'b1000);
      step();
      chk("R7 single strobe drops", 32'(shape_wr), 32'h0);
      do_bind(10'h380, 5'b01011, 0);
      do_asg(1, 5'b10100);
      state_is("R6 code 5 ignored", 10'h380, 5'b01011, 0, 4'b0000);
      do_asg(1, 5'b11111);
      state_is("R6 code 7 ignored", 10'h380, 5'b01011, 0, 4'b0000);
   endtask

   task automatic t_priority;
      bind_valid = 1; bind_sel = 10'h2AA; bind_en = 5'b00001; bind_persist = 0;
      asg_valid = 1; asg_single = 0; asg_mask = 5'b11111;
      step();
      state_is("R11 bind over assign", 10'h2AA, 5'b00001, 0, 4'b0000);
      asg_valid = 1; asg_single = 1; asg_mask = 5'b00001; vec_retire = 1;
      step();
      state_is("R11 assign over retire", 10'h2A9, 5'b10001, 1, 4'b0010);
      do_bind(10'h2A9, 5'b10001, 0);
      maxvl_set = 1; vec_retire = 1; step();
      state_is("R11 maxvl over retire", 10'h2A9, 5'b00000, 0, 4'b0000);
      do_asg(0, 5'b00000);
      state_is("R3 bulk zero mask", 10'h000, 5'b00000, 0, 4'b0000);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_bind_oneshot();
      t_persist();
      t_bulk();
      t_single();
      t_priority();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule